// File: doc/BRIEF.md
# Serial Peripheral DMA Channel Pair

This block moves data between one serial peripheral and memory with no processor involvement. It has two channels. The receive channel takes each character the peripheral reports as ready and writes it to memory. The transmit channel reads memory whenever the peripheral's transmit holding register is empty and hands the value to the peripheral. Each channel is driven by a memory pointer and a transfer count that software loads through a small register port. There are no descriptors. Once the count runs down to zero, the channel's end-of-transfer flag is set, and the owning peripheral reports that flag as its completion status.

Both channels share one memory port. It carries one access at a time and uses a request/acknowledge handshake. When both channels become eligible in the same cycle, the receive channel is served first, because a late receive access can overrun the peripheral's receiver. The unit size is either a byte or a halfword. It is taken from the peripheral's character width, and it sets both the access size and the pointer stride.

Top module: `serial_dma_pair`

## Requirements
- R1: After reset both pointers and both counts read as zero, both end flags are high, and no memory request is raised.
- R2: The register port is decoded as follows. Bit 1 of the address selects the channel (0 receive, 1 transmit). Bit 0 selects the field (0 pointer, 1 count). A write is accepted at the clock edge. `reg_rdata` shows the selected field combinationally, and the count is zero-extended.
- R3: A channel whose count is zero stays idle and keeps its end flag high, whatever the peripheral reports. A nonzero count arms it and clears its end flag.
- R4: An armed receive channel is granted only while `rx_ready` is high. In the grant cycle it pulses `rx_take` and captures `rx_data`. It then issues a memory write (`mem_we`=1) of that value at its pointer. In byte units the upper data bits are zero.
- R5: An armed transmit channel starts a memory read (`mem_we`=0) only while `tx_empty` is high. In the cycle of the acknowledge it pulses `tx_load` with `tx_data` equal to `mem_rdata`. In byte units `tx_data` is the low byte, zero-extended.
- R6: Each acknowledged access advances the owning channel's pointer by 1 in byte units or by 2 in halfword units, and lowers its count by one.
- R7: Once raised, `mem_req` stays high with stable address, direction, size and write data until `mem_ack`. Only one access is outstanding at a time.
- R8: When both channels are eligible in the same idle cycle, the receive channel is granted.
- R9: The end flag of a channel rises when the acknowledge of its last unit brings the count to zero. After that the channel raises no further request.
- R10: A register write to a channel is ignored while that channel holds the memory port or is granted in that cycle.
- R11: `mem_size` is 0 for byte units and 1 for halfword units. It is sampled from `unit_half` at grant and held for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: {channel, field} |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Selected register value |
| unit_half | input | 1 | Unit size: 0 byte, 1 halfword |
| rx_ready | input | 1 | Peripheral holds a received character |
| rx_data | input | DATA_W | Received character |
| rx_take | output | 1 | Character consumed by the receive channel |
| rx_end | output | 1 | Receive count is zero |
| tx_empty | input | 1 | Peripheral transmit holding register empty |
| tx_data | output | DATA_W | Character for the transmitter |
| tx_load | output | 1 | Load strobe for `tx_data` |
| tx_end | output | 1 | Transmit count is zero |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_size | output | 1 | 0 byte, 1 halfword |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |

## Verification
The bench builds the block with its default parameters: a 32-bit pointer, a 16-bit count and 16-bit data, so that the halfword stride is 2. With these values both unit sizes, pointer strides across byte and halfword boundaries, and count run-down to zero on short transfers are all within reach. Memory latency, peripheral gaps and simultaneous readiness of both channels are varied between transfers. This covers priority and the blocking of register writes while an access is held. Count wrap at the top of the 16-bit range is not reached.

// File: rtl/serial_dma_pair_pkg.sv
// Shared types for the serial DMA channel pair.
// Assumes two channels only: index 0 receive, index 1 transmit.
package serial_dma_pair_pkg;

    // Which channel currently owns the shared memory port
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_RX   = 2'd1,
        OWN_TX   = 2'd2
    } dma_owner_e;

    localparam int CH_RX = 0;
    localparam int CH_TX = 1;

endpackage

// File: rtl/serial_dma_pair_chan.sv
// One channel: memory pointer and unit counter.
// Loads from the register port are refused while the channel is locked
// (its access is granted or outstanding). Each completed access moves
// the pointer by the stride and lowers the count by one.
// Assumes done only arrives while the count is nonzero.
module serial_dma_pair_chan #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int STEP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_ptr,
    input  logic              load_cnt,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              locked,
    input  logic              done,
    input  logic [STEP_W-1:0] stride,
    output logic [ADDR_W-1:0] ptr,
    output logic [CNT_W-1:0]  cnt,
    output logic              armed
);

    // Pointer: software load when free, else advance on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load_ptr && !locked) begin
            ptr <= load_val;
        end else if (done) begin
            ptr <= ptr + ADDR_W'(stride);
        end
    end

    // Count: software load when free, else decrement on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_cnt && !locked) begin
            cnt <= CNT_W'(load_val);
        end else if (done) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // Channel is armed while units remain
    always_comb armed = (cnt != '0);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cnt == $past(cnt) - CNT_W'(1)); // R6
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ptr == $past(ptr) + ADDR_W'($past(stride))); // R6
    AST_DONE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> armed); // R9
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        locked && !done |=> $stable(cnt) && $stable(ptr)); // R10

endmodule

// File: rtl/serial_dma_pair_arb.sv
// Fixed-priority owner of the shared memory port.
// Grants in an idle cycle only, receive before transmit, and keeps the
// owner until the memory acknowledge. Assumes want is already qualified
// by the channel's count and the peripheral's status.
module serial_dma_pair_arb
    import serial_dma_pair_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] want,
    input  logic       ack,
    output dma_owner_e owner,
    output logic [1:0] grant
);

    // Grant decision: only from idle, receive has priority
    always_comb begin
        grant = 2'b00;
        if (owner == OWN_NONE) begin
            if (want[CH_RX])      grant = 2'b01;
            else if (want[CH_TX]) grant = 2'b10;
        end
    end

    // Ownership register: take on grant, release on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner <= OWN_NONE;
        end else if (owner == OWN_NONE) begin
            if (grant[CH_RX])      owner <= OWN_RX;
            else if (grant[CH_TX]) owner <= OWN_TX;
        end else if (ack) begin
            owner <= OWN_NONE;
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R8
    AST_OWNER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        owner != OWN_NONE && !ack |=> owner == $past(owner)); // R7
    AST_RX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        want[CH_RX] && owner == OWN_NONE |=> owner == OWN_RX); // R8

endmodule

// File: rtl/serial_dma_pair.sv
// Top: two DMA channels (receive, transmit) for one serial peripheral,
// sharing one request/acknowledge memory port.
// Assumes the peripheral drops rx_ready the cycle after rx_take and
// drops tx_empty the cycle after tx_load. Assumes mem_rdata is valid
// in the mem_ack cycle.
module serial_dma_pair
    import serial_dma_pair_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              unit_half,
    input  logic              rx_ready,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_take,
    output logic              rx_end,
    input  logic              tx_empty,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_load,
    output logic              tx_end,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_size,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int WIDE_STEP = DATA_W / 8;
    localparam int STEP_W    = $clog2(WIDE_STEP + 1);
    localparam int NCH       = 2;

    dma_owner_e                     owner;
    logic [NCH-1:0]                 grant;
    logic [NCH-1:0]                 want;
    logic [NCH-1:0]                 armed;
    logic [NCH-1:0]                 done;
    logic [NCH-1:0]                 locked;
    logic [NCH-1:0]                 ld_ptr;
    logic [NCH-1:0]                 ld_cnt;
    logic [NCH-1:0][ADDR_W-1:0]     ch_ptr;
    logic [NCH-1:0][CNT_W-1:0]      ch_cnt;
    logic                           size_q;
    logic [DATA_W-1:0]              wdata_q;
    logic [STEP_W-1:0]              stride;

    // Eligibility: armed channel with its peripheral condition present
    always_comb begin
        want[CH_RX] = armed[CH_RX] && rx_ready;
        want[CH_TX] = armed[CH_TX] && tx_empty;
    end

    serial_dma_pair_arb u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .want  (want),
        .ack   (mem_ack),
        .owner (owner),
        .grant (grant)
    );

    // Stride follows the unit size held for the access in flight
    always_comb stride = size_q ? STEP_W'(WIDE_STEP) : STEP_W'(1);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam dma_owner_e ME = (c == CH_RX) ? OWN_RX : OWN_TX;

        // Per-channel decode, lock and completion
        always_comb begin
            ld_ptr[c] = reg_wr && (reg_addr == {1'(c), 1'b0});
            ld_cnt[c] = reg_wr && (reg_addr == {1'(c), 1'b1});
            locked[c] = (owner == ME) || grant[c];
            done[c]   = mem_ack && (owner == ME);
        end

        serial_dma_pair_chan #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W),
            .STEP_W (STEP_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_ptr (ld_ptr[c]),
            .load_cnt (ld_cnt[c]),
            .load_val (reg_wdata),
            .locked   (locked[c]),
            .done     (done[c]),
            .stride   (stride),
            .ptr      (ch_ptr[c]),
            .cnt      (ch_cnt[c]),
            .armed    (armed[c])
        );
    end

    // Access attributes captured at grant and held until acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q  <= 1'b0;
            wdata_q <= '0;
        end else if (grant != '0) begin
            size_q <= unit_half;
            if (grant[CH_RX]) begin
                wdata_q <= unit_half ? rx_data
                                     : {{(DATA_W-8){1'b0}}, rx_data[7:0]};
            end
        end
    end

    // Memory port driven from the owner
    always_comb begin
        mem_req   = (owner != OWN_NONE);
        mem_we    = (owner == OWN_RX);
        mem_size  = size_q;
        mem_wdata = wdata_q;
        mem_addr  = (owner == OWN_TX) ? ch_ptr[CH_TX] : ch_ptr[CH_RX];
    end

    // Peripheral side strobes and completion flags
    always_comb begin
        rx_take = grant[CH_RX];
        tx_load = done[CH_TX];
        tx_data = size_q ? mem_rdata : {{(DATA_W-8){1'b0}}, mem_rdata[7:0]};
        rx_end  = !armed[CH_RX];
        tx_end  = !armed[CH_TX];
    end

    // Register read mux, count zero-extended
    always_comb begin
        if (reg_addr[0]) reg_rdata = {{(ADDR_W-CNT_W){1'b0}}, ch_cnt[reg_addr[1]]};
        else             reg_rdata = ch_ptr[reg_addr[1]];
    end

    AST_TAKE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_take |-> rx_ready && !rx_end); // R4
    AST_LOAD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> mem_req && !mem_we && mem_ack); // R5
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_size) && $stable(mem_wdata)); // R7
    AST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rx_end && tx_end |-> !mem_req); // R9
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !rx_end); // R3

endmodule

// File: tb/sim_serial_dma_pair.sv
// Bench: behavioural cycle model of both channels, the peripheral and
// the memory, compared with the ports on every clock.
module sim_serial_dma_pair;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        unit_half = 1'b0;
    logic        rx_ready = 1'b0;
    logic [15:0] rx_data = '0;
    logic        rx_take, rx_end, tx_load, tx_end;
    logic        tx_empty = 1'b0;
    logic [15:0] tx_data;
    logic        mem_req, mem_we, mem_size;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;

    serial_dma_pair u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_err = 0;
    logic [7:0]  mem_dut [1024];
    logic [7:0]  mem_ref [1024];
    logic [31:0] ref_ptr [2];
    int          ref_cnt [2];
    int          owner = -1;
    bit          ref_half = 0;
    logic [15:0] ref_wd = '0;
    int rx_supply = 0, rx_gap = 0, rx_gap_cfg = 0, rx_seq = 0;
    bit tx_on = 0;
    int tx_gap = 0, tx_gap_cfg = 0, tx_count = 0;
    int lat = 0, wait_c = 0, req_seen = 0;
    bit pw = 0, pr_en = 0;
    logic [1:0]  pa = 0, pr_a = 0, rr = 0;
    logic [31:0] pd = 0, last_rd = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // One clock of stimulus, checking and model update
    task automatic cycle();
        logic [9:0]  a;
        logic [31:0] exp_rd;
        logic [15:0] exp_tx;
        int g, own0, ch;
        @(negedge clk);
        if (mem_req) req_seen++;
        if (mem_req && wait_c >= lat) begin
            mem_ack = 1'b1;
            a = mem_addr[9:0];
            mem_rdata = mem_size ? {mem_dut[a + 10'd1], mem_dut[a]} : {8'hA5, mem_dut[a]};
            wait_c = 0;
        end else begin
            mem_ack = 1'b0;
            if (mem_req) wait_c++;
        end
        rx_ready = (rx_supply > 0) && (rx_gap == 0);
        rx_data  = 16'(rx_seq * 40503 + 17);
        tx_empty = tx_on && (tx_gap == 0);
        if (pw) begin
            reg_wr = 1'b1; reg_addr = pa; reg_wdata = pd; pw = 0;
        end else begin
            reg_wr = 1'b0;
            if (pr_en) reg_addr = pr_a;
            else begin reg_addr = rr; rr = rr + 2'd1; end
        end
        #1;
        if (pr_en) begin last_rd = reg_rdata; pr_en = 0; end
        exp_rd = reg_addr[0] ? 32'(ref_cnt[reg_addr[1]]) : ref_ptr[reg_addr[1]];
        chk(reg_rdata == exp_rd, "R2 readback", reg_rdata, exp_rd);
        chk(rx_end == (ref_cnt[0] == 0), "R9 rx_end", 32'(rx_end), 32'(ref_cnt[0] == 0));
        chk(tx_end == (ref_cnt[1] == 0), "R9 tx_end", 32'(tx_end), 32'(ref_cnt[1] == 0));
        g = -1;
        if (owner < 0) begin
            if (ref_cnt[0] != 0 && rx_ready) g = 0;
            else if (ref_cnt[1] != 0 && tx_empty) g = 1;
        end
        chk(rx_take == (g == 0), "R4/R8 rx_take", 32'(rx_take), 32'(g == 0));
        chk(mem_req == (owner >= 0), "R7 mem_req", 32'(mem_req), 32'(owner >= 0));
        if (owner >= 0) begin
            chk(mem_addr == ref_ptr[owner], "R6 mem_addr", mem_addr, ref_ptr[owner]);
            chk(mem_we == (owner == 0), "R5 mem_we", 32'(mem_we), 32'(owner == 0));
            chk(mem_size == ref_half, "R11 mem_size", 32'(mem_size), 32'(ref_half));
            if (owner == 0) chk(mem_wdata == ref_wd, "R4 mem_wdata", 32'(mem_wdata), 32'(ref_wd));
        end
        chk(tx_load == (owner == 1 && mem_ack), "R5 tx_load", 32'(tx_load), 32'(owner == 1 && mem_ack));
        if (owner == 1 && mem_ack) begin
            a = ref_ptr[1][9:0];
            exp_tx = ref_half ? {mem_ref[a + 10'd1], mem_ref[a]} : {8'h00, mem_ref[a]};
            chk(tx_data == exp_tx, "R5 tx_data", 32'(tx_data), 32'(exp_tx));
        end
        // model update
        own0 = owner;
        if (owner >= 0 && mem_ack) begin
            if (owner == 0) begin
                a = ref_ptr[0][9:0];
                mem_ref[a] = ref_wd[7:0];
                if (ref_half) mem_ref[a + 10'd1] = ref_wd[15:8];
                a = mem_addr[9:0];
                mem_dut[a] = mem_wdata[7:0];
                if (mem_size) mem_dut[a + 10'd1] = mem_wdata[15:8];
            end
            ref_ptr[owner] = ref_ptr[owner] + (ref_half ? 32'd2 : 32'd1);
            ref_cnt[owner] = ref_cnt[owner] - 1;
            owner = -1;
        end else if (owner < 0 && g >= 0) begin
            owner = g;
            ref_half = unit_half;
            if (g == 0) ref_wd = unit_half ? rx_data : {8'h00, rx_data[7:0]};
        end
        if (reg_wr) begin
            ch = int'(reg_addr[1]);
            if (own0 != ch && g != ch) begin
                if (reg_addr[0]) ref_cnt[ch] = int'(reg_wdata[15:0]);
                else ref_ptr[ch] = reg_wdata;
            end
        end
        // peripheral models
        if (rx_take) begin rx_supply--; rx_seq++; rx_gap = rx_gap_cfg; end
        else if (rx_gap > 0) rx_gap--;
        if (tx_load) begin tx_gap = tx_gap_cfg + 1; tx_count++; end
        else if (tx_gap > 0) tx_gap--;
    endtask

    task automatic wr(input logic [1:0] ad, input logic [31:0] d);
        pw = 1; pa = ad; pd = d; cycle();
    endtask

    task automatic peek(input logic [1:0] ad);
        pr_en = 1; pr_a = ad; cycle();
    endtask

    task automatic drain();
        for (int i = 0; i < 400 && (ref_cnt[0] != 0 || ref_cnt[1] != 0 || owner >= 0); i++) cycle();
        cycle();
    endtask

    task automatic mem_cmp(input string tag);
        int bad = 0;
        for (int i = 0; i < 1024; i++) if (mem_dut[i] !== mem_ref[i]) bad++;
        chk(bad == 0, tag, 32'(bad), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem_dut[i] = 8'(i * 7 + 3);
            mem_ref[i] = 8'(i * 7 + 3);
        end
        ref_ptr[0] = 0; ref_ptr[1] = 0; ref_cnt[0] = 0; ref_cnt[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(rx_end == 1'b1, "R1 rx_end", 32'(rx_end), 32'd1);
        chk(tx_end == 1'b1, "R1 tx_end", 32'(tx_end), 32'd1);
        chk(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 32'd0);
        chk(reg_rdata == 32'd0, "R1 rx ptr", reg_rdata, 32'd0);
        repeat (4) cycle();

        // R3: zero counts stay idle despite peripheral activity
        rx_supply = 3; tx_on = 1; req_seen = 0;
        repeat (12) cycle();
        chk(req_seen == 0, "R3 idle with zero count", 32'(req_seen), 32'd0);
        chk(rx_supply == 3, "R3 no characters taken", 32'(rx_supply), 32'd3);
        tx_on = 0; rx_supply = 0;
        cycle();

        // Receive 5 bytes at 0x100
        unit_half = 0; lat = 1; rx_gap_cfg = 2;
        wr(2'b00, 32'h100); wr(2'b01, 32'd5);
        rx_supply = 5;
        drain();
        chk(rx_end == 1'b1, "R9 rx done", 32'(rx_end), 32'd1);
        peek(2'b00);
        chk(last_rd == 32'h105, "R6 rx byte pointer", last_rd, 32'h105);
        mem_cmp("R4 memory after byte receive");

        // Transmit those 5 bytes
        lat = 0; tx_gap_cfg = 1; tx_count = 0;
        wr(2'b10, 32'h100); wr(2'b11, 32'd5);
        tx_on = 1;
        drain();
        tx_on = 0;
        chk(tx_count == 5, "R5 byte loads", 32'(tx_count), 32'd5);
        chk(tx_end == 1'b1, "R9 tx done", 32'(tx_end), 32'd1);
        peek(2'b10);
        chk(last_rd == 32'h105, "R6 tx byte pointer", last_rd, 32'h105);

        // Halfword units, both channels eligible together
        unit_half = 1; lat = 2; rx_gap_cfg = 0; tx_gap_cfg = 0; tx_count = 0;
        wr(2'b00, 32'h200); wr(2'b01, 32'd7);
        wr(2'b10, 32'h100); wr(2'b11, 32'd3);
        rx_supply = 7; tx_on = 1;
        cycle();
        chk(rx_take == 1'b1, "R8 receive wins", 32'(rx_take), 32'd1);
        drain();
        tx_on = 0;
        chk(tx_count == 3, "R5 halfword loads", 32'(tx_count), 32'd3);
        peek(2'b00);
        chk(last_rd == 32'h20E, "R6 rx halfword pointer", last_rd, 32'h20E);
        peek(2'b10);
        chk(last_rd == 32'h106, "R6 tx halfword pointer", last_rd, 32'h106);
        mem_cmp("R4 memory after halfword receive");

        // R10: writes refused while the channel holds the port
        unit_half = 0; lat = 4;
        wr(2'b00, 32'h300); wr(2'b01, 32'd2);
        rx_supply = 2;
        for (int i = 0; i < 20 && !mem_req; i++) cycle();
        wr(2'b01, 32'd9);
        wr(2'b00, 32'h3F0);
        drain();
        peek(2'b01);
        chk(last_rd == 32'd0, "R10 count write ignored", last_rd, 32'd0);
        peek(2'b00);
        chk(last_rd == 32'h302, "R10 pointer write ignored", last_rd, 32'h302);
        mem_cmp("R4 memory final");

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule